// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This peripheral keeps a 16-bit up-counter. Software sees it through four byte-wide registers. The counter advances on one of two sources: an instruction-rate tick from the core, or an external clock pin. The external source can either pass through a two-stage synchronizer with rising-edge detection, or take a direct edge-detect path that bypasses the synchronizer. A two-bit prescale field divides whichever source is chosen by 1, 2, 4 or 8 before it reaches the counter. Software cannot see the prescaler. Any write to a count byte clears it.

When the counter wraps from FFFFh to 0000h, a sticky overflow flag is set. Two outputs are built from this flag. The interrupt request needs the flag, a local enable held in the status register, a peripheral enable input and a global enable input. The wake-up request needs the same terms except the global enable. While the low-power stop input is high, only the bypassed external path keeps counting. Setting an oscillator-enable control bit makes the block tell the port logic to force its two shared pins to input.

Register map (`addr`): 0 = count bits 7:0, 1 = count bits 15:8, 2 = control, 3 = status. Control bits: [0] run, [1] external source, [2] synchronizer bypass, [3] oscillator enable, [5:4] prescale select, [7:6] read as zero. Status bits: [0] overflow flag, [1] timer interrupt enable, [7:2] read as zero.

Top module: `tmr16_periph`

## Requirements
- R1: After reset, all four registers read 00h, and `irq_o`, `wake_o` and `pin_in_force_o` are low.
- R2: A write to address 0 or 1 loads that count byte at the next clock edge. The other byte keeps its value, and the write replaces any increment due in that cycle.
- R3: With control bit 0 (run) clear, the count never changes except by a byte write. With run set and the internal source chosen (bit 1 = 0) at divide-by-1, each `tick_i` pulse raises the count by one at the edge where it is sampled.
- R4: Prescale select 0, 1, 2 and 3 (control bits 5:4) advances the count once per 1, 2, 4 and 8 qualified source pulses, respectively.
- R5: Any write to address 0 or 1 clears the hidden prescale count, so a full division period starts again after the write.
- R6: The count wraps from FFFFh to 0000h, and on that wrap status bit 0 is set. The bit only changes when software writes status bit 0. A wrap in the same cycle as a status write leaves the bit set.
- R7: `irq_o` is high exactly when status bit 0, status bit 1, `peie_i` and `gie_i` are all high.
- R8: `wake_o` is high exactly when status bit 0, status bit 1 and `peie_i` are high, whatever the value of `gie_i`.
- R9: With the external source chosen and bit 2 clear, each rising edge of `ext_clk_i` yields one count, visible after the third clock edge following the rise. With bit 2 set, the count is visible after the first edge. A level held high adds nothing.
- R10: While `sleep_i` is high, the internal tick and the synchronized external path do not count, and the bypassed external path still counts.
- R11: `pin_in_force_o` follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-rate count pulse |
| ext_clk_i | input | 1 | External count clock |
| sleep_i | input | 1 | Low-power stop state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Read data (combinational) |
| peie_i | input | 1 | Peripheral interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| pin_in_force_o | output | 1 | Force the shared pins to input |

## Verification
On every cycle, the assertions check the following: byte loads land in the right half, a halted counter holds its value, the count never moves by more than one per cycle, a wrap always leaves the flag set, the flag stays sticky without a status write, and the interrupt request always sits inside the wake-up request. Some behaviour depends on how many source pulses have been seen, so only the bench's scenarios can show it: the prescaler period, the prescaler reset by a count write, the clock-edge latency of the synchronized and bypassed paths, and which paths keep counting during sleep. The bench's reference model also compares every output on every cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PS_W   = 2;

  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            osc_en;
    logic            sync_bypass;
    logic            src_ext;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic hold_i,
  output logic sync_rise_o,
  output logic raw_rise_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, raw_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign chain_d[g] = ext_i;
    end else begin : g_next
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
      raw_q   <= ext_i;
    end
  end

  assign sync_rise_o = chain_q[STAGES-1] & ~last_q & ~hold_i;
  assign raw_rise_o  = ext_i & ~raw_q;
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_d, mask;
  logic [DIV_W:0]   span;

  always_comb begin
    span   = (DIV_W+1)'(1) << sel_i;
    mask   = DIV_W'(span - 1'b1);
    tick_o = pulse_i & ((pre_q & mask) == mask);
    if (clr_i)        pre_d = '0;
    else if (pulse_i) pre_d = pre_q + 1'b1;
    else              pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int W      = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [W-1:0]      cnt_o,
  output logic              wrap_o
);
  localparam int HI_W = W - BYTE_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic         load;

  always_comb begin
    load   = ld_lo_i | ld_hi_i;
    wrap_o = inc_i & ~load & (&cnt_q);
    cnt_d  = cnt_q;
    if (ld_lo_i)    cnt_d[BYTE_W-1:0] = data_i;
    else if (ld_hi_i) cnt_d[W-1:BYTE_W] = HI_W'(data_i);
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ext_clk_i,
  input  logic       sleep_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic       peie_i,
  input  logic       gie_i,
  output logic       irq_o,
  output logic       wake_o,
  output logic       pin_in_force_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q, ctrl_d;
  logic              flag_q, flag_d, tie_q, tie_d;
  logic              wr_lo, wr_hi, wr_ctrl, wr_stat, cnt_wr;
  logic              sync_rise, raw_rise, int_pulse, ext_pulse, qual, inc, wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_w;

  assign wr_lo   = wr_en_i & (wr_addr_i == A_CNT_LO);
  assign wr_hi   = wr_en_i & (wr_addr_i == A_CNT_HI);
  assign wr_ctrl = wr_en_i & (wr_addr_i == A_CTRL);
  assign wr_stat = wr_en_i & (wr_addr_i == A_STAT);
  assign cnt_wr  = wr_lo | wr_hi;
  assign run_w   = ctrl_q.run;

  tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_clk_i), .hold_i(sleep_i),
    .sync_rise_o(sync_rise), .raw_rise_o(raw_rise)
  );

  assign int_pulse = tick_i & ~sleep_i;
  assign ext_pulse = ctrl_q.sync_bypass ? raw_rise : sync_rise;
  assign qual      = ctrl_q.run & (ctrl_q.src_ext ? ext_pulse : int_pulse);

  tmr16_prescale #(.SEL_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_wr), .pulse_i(qual),
    .sel_i(ctrl_q.ps), .tick_o(inc)
  );

  tmr16_counter #(.W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .ld_lo_i(wr_lo), .ld_hi_i(wr_hi),
    .data_i(wr_data_i), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(wr_data_i[CTRL_W-1:0]) : ctrl_q;
    tie_d  = wr_stat ? wr_data_i[1] : tie_q;
    if (wrap)         flag_d = 1'b1;
    else if (wr_stat) flag_d = wr_data_i[0];
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      tie_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      tie_q  <= tie_d;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CNT_LO: rd_data_o = cnt_q[BYTE_W-1:0];
      A_CNT_HI: rd_data_o = cnt_q[CNT_W-1:BYTE_W];
      A_CTRL:   rd_data_o = 8'(ctrl_q);
      default:  rd_data_o = {6'b0, tie_q, flag_q};
    endcase
  end

  assign wake_o         = flag_q & tie_q & peie_i;
  assign irq_o          = wake_o & gie_i;
  assign pin_in_force_o = ctrl_q.osc_en;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [15:0] cnt,
  input logic        flag,
  input logic        run,
  input logic        gie,
  input logic        irq,
  input logic        wake
);
  logic cnt_wr, stat_wr;
  assign cnt_wr  = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
  assign stat_wr = wr_en && (wr_addr == 2'd3);

  AST_LOW_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (cnt[7:0] == $past(wr_data)));  // R2
  AST_HIGH_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> (cnt[15:8] == $past(wr_data)));  // R2
  AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));  // R3
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == 16'($past(cnt) + 16'd1)));  // R4
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !cnt_wr) |=> (cnt != 16'h0000 || flag));  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_wr) |=> flag);  // R6
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);  // R7
  AST_IRQ_WITHIN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);  // R7
  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> flag);  // R8
endmodule

bind tmr16_periph tmr16_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .cnt(cnt_q), .flag(flag_q), .run(run_w),
  .gie(gie_i), .irq(irq_o), .wake(wake_o)
);

// File: tb/tmr16_periph_test.sv
`timescale 1ns/100ps
module tmr16_periph_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tick, ext, sleep, wr_en, peie, gie;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq, wake, pin;

  tmr16_periph uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_clk_i(ext), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .peie_i(peie), .gie_i(gie), .irq_o(irq), .wake_o(wake),
    .pin_in_force_o(pin)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_pre;
  bit m_flag, m_tie;
  bit [5:0] m_ctrl;
  bit e1, e2, e3, eb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_flag = 0; m_tie = 0; m_ctrl = 0;
      e1 = 0; e2 = 0; e3 = 0; eb = 0;
    end else begin
      bit ip, sp, bp, src, q, inc, cw, wrap;
      int mask;
      ip = tick && !sleep;
      sp = e2 && !e3 && !sleep;
      bp = ext && !eb;
      src = m_ctrl[1] ? (m_ctrl[2] ? bp : sp) : ip;
      q = m_ctrl[0] && src;
      mask = (1 << int'(m_ctrl[5:4])) - 1;
      inc = q && ((m_pre & mask) == mask);
      cw = wr_en && (wr_addr < 2);
      wrap = inc && !cw && (m_cnt == 'hFFFF);
      if (cw) m_pre = 0; else if (q) m_pre = (m_pre + 1) % 8;
      if (wr_en && wr_addr == 0) m_cnt = (m_cnt & 'hFF00) | int'(wr_data);
      else if (wr_en && wr_addr == 1) m_cnt = (m_cnt & 'hFF) | (int'(wr_data) << 8);
      else if (inc) m_cnt = (m_cnt + 1) % 65536;
      if (wrap) m_flag = 1; else if (wr_en && wr_addr == 3) m_flag = wr_data[0];
      if (wr_en && wr_addr == 3) m_tie = wr_data[1];
      if (wr_en && wr_addr == 2) m_ctrl = wr_data[5:0];
      e3 = e2; e2 = e1; e1 = ext; eb = ext;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_cnt & 'hFF;
      1: return (m_cnt >> 8) & 'hFF;
      2: return int'(m_ctrl);
      default: return (int'(m_tie) << 1) | int'(m_flag);
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R7 irq vs model", irq, m_flag & m_tie & peie & gie);
      check("R8 wake vs model", wake, m_flag & m_tie & peie);
      check("R11 pin force vs model", pin, m_ctrl[3]);
      check("R2 rd_data vs model", rd_data, m_read(rd_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd_now(input logic [1:0] a, output int v);
    rd_addr = a; #0.2; v = int'(rd_data);
  endtask

  task automatic cnt_now(output int v);
    int lo, hi;
    rd_now(2'd0, lo); rd_now(2'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic expect_cnt(string tag, int exp);
    int v;
    @(negedge clk); cnt_now(v); check(tag, v, exp);
  endtask

  task automatic expect_reg(string tag, logic [1:0] a, int exp);
    int v;
    @(negedge clk); rd_now(a, v); check(tag, v, exp);
  endtask

  int v0, v1;

  initial begin
    rst_n = 0; tick = 0; ext = 0; sleep = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    rd_addr = 0; peie = 0; gie = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) expect_reg("R1 reset reg", 2'(a), 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset wake", wake, 0);
    check("R1 reset pin", pin, 0);

    // R2 byte loads
    wr(0, 8'h34); wr(1, 8'h12);
    expect_cnt("R2 byte load", 'h1234);

    // R3 internal counting and halt
    wr(2, 8'h01);
    ticks(5);
    expect_cnt("R3 internal count", 'h1239);
    wr(2, 8'h00);
    ticks(3);
    expect_cnt("R3 halted", 'h1239);

    // R4 prescale ratios
    wr(0, 0); wr(1, 0); wr(2, 8'h21);
    ticks(8);
    expect_cnt("R4 divide by 4", 2);
    wr(2, 8'h31); wr(0, 0);
    ticks(16);
    expect_cnt("R4 divide by 8", 2);
    wr(2, 8'h11); wr(0, 0);
    ticks(6);
    expect_cnt("R4 divide by 2", 3);

    // R5 prescaler cleared by a count write
    wr(2, 8'h31); wr(0, 0);
    ticks(5);
    wr(0, 8'h40);
    ticks(7);
    expect_cnt("R5 prescaler cleared, 7 pulses", 'h40);
    ticks(1);
    expect_cnt("R5 prescaler cleared, 8 pulses", 'h41);

    // R2 write overrides same-cycle increment
    wr(2, 8'h01); wr(0, 8'h10); wr(1, 8'h00);
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h77;
    @(negedge clk); tick = 0; wr_en = 0;
    expect_cnt("R2 write beats increment", 'h7710);

    // R6 wrap and sticky flag
    wr(0, 8'hFE); wr(1, 8'hFF);
    ticks(1);
    expect_cnt("R6 at FFFF", 'hFFFF);
    expect_reg("R6 flag clear before wrap", 2'd3, 0);
    ticks(1);
    expect_cnt("R6 wrapped", 0);
    expect_reg("R6 flag set on wrap", 2'd3, 1);
    wr(0, 8'h05);
    expect_reg("R6 flag sticky on count write", 2'd3, 1);
    wr(3, 8'h00);
    expect_reg("R6 flag cleared by software", 2'd3, 0);
    wr(0, 8'hFF); wr(1, 8'hFF);
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 3; wr_data = 8'h00;
    @(negedge clk); tick = 0; wr_en = 0;
    expect_reg("R6 wrap beats clear", 2'd3, 1);

    // R7 / R8 enable combinations with flag set, then cleared
    for (int c = 0; c < 8; c++) begin
      wr(3, {6'b0, c[2], 1'b1});
      @(negedge clk); peie = c[1]; gie = c[0];
      #1;
      check("R7 irq gating", irq, c[2] & c[1] & c[0]);
      check("R8 wake gating", wake, c[2] & c[1]);
    end
    wr(3, 8'h02);
    @(negedge clk); peie = 1; gie = 1; #1;
    check("R7 irq needs flag", irq, 0);
    check("R8 wake needs flag", wake, 0);
    peie = 0; gie = 0;

    // R9 synchronized external path
    wr(3, 0); wr(0, 0); wr(1, 0); wr(2, 8'h03);
    @(negedge clk); ext = 1;
    @(negedge clk); @(negedge clk); cnt_now(v0);
    check("R9 sync not yet after 2 edges", v0, 0);
    @(negedge clk); cnt_now(v0);
    check("R9 sync count after 3 edges", v0, 1);
    repeat (5) @(negedge clk);
    cnt_now(v0);
    check("R9 held level adds nothing", v0, 1);
    ext = 0; repeat (3) @(negedge clk); ext = 1;
    repeat (4) @(negedge clk);
    cnt_now(v0);
    check("R9 second edge", v0, 2);
    // bypass path
    ext = 0; repeat (4) @(negedge clk);
    wr(2, 8'h07);
    @(negedge clk); ext = 1;
    @(negedge clk); cnt_now(v0);
    check("R9 bypass after 1 edge", v0, 3);

    // R10 sleep
    ext = 0; repeat (4) @(negedge clk);
    sleep = 1;
    wr(2, 8'h01);
    ticks(4);
    expect_cnt("R10 internal stopped in sleep", 3);
    wr(2, 8'h03);
    @(negedge clk); ext = 1; repeat (5) @(negedge clk);
    cnt_now(v0);
    check("R10 sync stopped in sleep", v0, 3);
    ext = 0; repeat (4) @(negedge clk);
    wr(2, 8'h07);
    @(negedge clk); ext = 1;
    @(negedge clk); cnt_now(v1);
    check("R10 bypass runs in sleep", v1, 4);
    ext = 0; sleep = 0;

    // R11 pin force
    wr(2, 8'h08);
    @(negedge clk); #1; check("R11 pin force on", pin, 1);
    wr(2, 8'h00);
    @(negedge clk); #1; check("R11 pin force off", pin, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule